// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor

This block predicts the direction and target of conditional branches for the front end of a simple pipelined core. A small direct-mapped target buffer is looked up with the fetch address, so a branch seen before can be predicted before it is decoded. Each entry holds a valid bit, an address tag, a target and a 2-bit saturating direction counter. The lookup answer (hit, taken, target) appears one cycle after the request.

When the buffer has no prediction, the decode stage fills the gap. Decode supplies the buffer result carried from fetch, the sign of the branch displacement and an optional software direction hint. The block then gives a final direction with this priority: a buffer hit wins, then a hint, then a static rule (backward taken, forward not taken). The buffer changes only when a branch retires. A taken branch that misses is allocated, and a branch that hits trains its counter.

Top module: `hybrid_bpred`

## Requirements
- R1: After synchronous reset every entry is invalid, so each lookup misses (lk_hit_o low, lk_taken_o low) until a taken branch has retired at that address.
- R2: A lookup with lk_valid_i high gives its result on the next clock edge. The index is address bits [5:2] (16 entries) and the tag is all other address bits. It hits when that entry is valid and its tag equals the one stored.
- R3: With no buffer hit and hint 00 or 11, a branch with negative displacement (dec_disp_neg_i=1) is predicted taken, with dir_src_o=2'b00 (static).
- R4: With no buffer hit and hint 00 or 11, a branch with non-negative displacement is predicted not taken, with dir_src_o=2'b00.
- R5: With no buffer hit, hint 2'b10 predicts taken and hint 2'b01 predicts not taken, whatever the displacement sign, with dir_src_o=2'b01 (hint).
- R6: When dec_btb_hit_i is high, dir_taken_o equals dec_btb_taken_i whatever the hint and sign, with dir_src_o=2'b10 (buffer).
- R7: A taken retire that misses allocates the entry: it stores the tag and target and sets the counter to 2. A later lookup then hits, predicts taken and returns that target.
- R8: A not-taken retire that misses allocates nothing. The entry already at that index, if any, keeps hitting with its prediction.
- R9: A retire that hits moves the counter up by one when taken and down by one when not taken, saturating at 3 and 0. A hit predicts taken when the counter is 2 or 3.
- R10: A taken retire that hits rewrites the target. A not-taken retire that hits leaves the target unchanged.
- R11: A lookup and a retire on the same index in the same cycle: the lookup returns the entry as it was before that retire.
- R12: dir_valid_o follows dec_valid_i with one cycle of latency. dir_taken_o and dir_src_o give the decision for the branch presented in that earlier cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Fetch address of the lookup |
| lk_hit_o | output | 1 | Lookup found a valid matching entry (next cycle) |
| lk_taken_o | output | 1 | Lookup predicts taken (next cycle) |
| lk_target_o | output | 32 | Predicted target, meaningful when lk_hit_o is high |
| dec_valid_i | input | 1 | A decoded conditional branch is presented |
| dec_btb_hit_i | input | 1 | Buffer hit carried from this branch's lookup |
| dec_btb_taken_i | input | 1 | Buffer direction carried from this branch's lookup |
| dec_disp_neg_i | input | 1 | Displacement is negative (backward branch) |
| dec_hint_i | input | 2 | 00 none, 01 not taken, 10 taken, 11 treated as none |
| dir_valid_o | output | 1 | Final direction valid (next cycle) |
| dir_taken_o | output | 1 | Final direction |
| dir_src_o | output | 2 | Decision source: 00 static, 01 hint, 10 buffer |
| rt_valid_i | input | 1 | A conditional branch retires |
| rt_addr_i | input | 32 | Address of the retiring branch |
| rt_taken_i | input | 1 | Resolved direction |
| rt_target_i | input | 32 | Resolved target |

## Verification
Directed sequences drive a single address through allocation, not-taken training down to 0 and back up. This shows whether the counter saturates and where prediction flips between 1 and 2. Aliasing pairs share one index with different tags, and they show tag comparison and the rule that a not-taken miss must not evict. Same-cycle retire and lookup on one index tells read-before-write apart from write-through. Every hint code is crossed with both displacement signs and with buffer hit or miss, which separates the three priority levels. Random traffic over a small pool of addresses (4 tags × 16 indexes) gives many hits, conflicts and retrain cycles. It is checked against a bench model of the buffer.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    HINT_NONE  = 2'b00,
    HINT_NTKN  = 2'b01,
    HINT_TKN   = 2'b10,
    HINT_RSVD  = 2'b11
  } hint_e;

  typedef enum logic [1:0] {
    SRC_STATIC = 2'b00,
    SRC_HINT   = 2'b01,
    SRC_BTB    = 2'b10
  } dir_src_e;

  localparam logic [1:0] CTR_ALLOC = 2'd2;

  function automatic logic [1:0] ctr_train(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
    else       nxt = (cur == 2'd0) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bpred_tgt_ram.sv
module bpred_tgt_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW_I = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW_I-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic            re,
  input  logic [AW_I-1:0] raddr,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bpred_btb_meta.sv
module bpred_btb_meta
  import bpred_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TAG_W = 28,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [IW-1:0]    lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit_q,
  output logic             lk_ctr_hi_q,
  input  logic             rt_valid,
  input  logic [IW-1:0]    rt_idx,
  input  logic [TAG_W-1:0] rt_tag,
  input  logic             rt_taken,
  output logic             tgt_we
);
  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [1:0]       ctr_q [DEPTH];
  logic             rt_match;

  assign rt_match = valid_q[rt_idx] && (tag_q[rt_idx] == rt_tag);
  assign tgt_we   = rt_valid && rt_taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (rt_valid && rt_taken && !rt_match) begin
      valid_q[rt_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rt_valid) begin
      if (rt_match) begin
        ctr_q[rt_idx] <= ctr_train(ctr_q[rt_idx], rt_taken);
      end else if (rt_taken) begin
        tag_q[rt_idx] <= rt_tag;
        ctr_q[rt_idx] <= CTR_ALLOC;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit_q    <= 1'b0;
      lk_ctr_hi_q <= 1'b0;
    end else begin
      lk_hit_q    <= lk_valid && valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
      lk_ctr_hi_q <= ctr_q[lk_idx][1];
    end
  end

  // R1: first lookup result after reset is a miss
  a_r1_reset_miss: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit_q);

  // R7: a taken retire leaves its entry valid
  a_r7_alloc_valid: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && rt_taken) |=> valid_q[$past(rt_idx)]);

  // R8: a not-taken miss changes no valid bit
  a_r8_no_alloc: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && !rt_taken && !rt_match) |=> (valid_q == $past(valid_q)));

  // R9: counter saturates at the top
  a_r9_ctr_sat_hi: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && rt_taken && rt_match && ctr_q[rt_idx] == 2'd3)
      |=> (ctr_q[$past(rt_idx)] == 2'd3));

  // R9: counter saturates at the bottom
  a_r9_ctr_sat_lo: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && !rt_taken && rt_match && ctr_q[rt_idx] == 2'd0)
      |=> (ctr_q[$past(rt_idx)] == 2'd0));
endmodule

// File: rtl/bpred_dir_select.sv
module bpred_dir_select
  import bpred_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dec_valid,
  input  logic       btb_hit,
  input  logic       btb_taken,
  input  logic       disp_neg,
  input  logic [1:0] hint,
  output logic       dir_valid_q,
  output logic       dir_taken_q,
  output logic [1:0] dir_src_q
);
  logic     taken_d;
  dir_src_e src_d;

  always_comb begin
    if (btb_hit) begin
      taken_d = btb_taken;
      src_d   = SRC_BTB;
    end else begin
      unique case (hint_e'(hint))
        HINT_TKN:  begin taken_d = 1'b1;     src_d = SRC_HINT;   end
        HINT_NTKN: begin taken_d = 1'b0;     src_d = SRC_HINT;   end
        default:   begin taken_d = disp_neg; src_d = SRC_STATIC; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_valid_q <= 1'b0;
      dir_taken_q <= 1'b0;
      dir_src_q   <= SRC_STATIC;
    end else begin
      dir_valid_q <= dec_valid;
      dir_taken_q <= taken_d;
      dir_src_q   <= src_d;
    end
  end

  // R3: backward branch without hit or hint is taken
  a_r3_backward_taken: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !btb_hit && (hint == 2'b00 || hint == 2'b11) && disp_neg)
      |=> (dir_taken_q && dir_src_q == 2'b00));

  // R4: forward branch without hit or hint is not taken
  a_r4_forward_ntkn: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !btb_hit && (hint == 2'b00 || hint == 2'b11) && !disp_neg)
      |=> (!dir_taken_q && dir_src_q == 2'b00));

  // R5: hint decides when there is no hit
  a_r5_hint_rules: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !btb_hit && (hint == 2'b01 || hint == 2'b10))
      |=> (dir_taken_q == $past(hint[1]) && dir_src_q == 2'b01));

  // R6: a buffer hit is never overridden
  a_r6_hit_wins: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && btb_hit)
      |=> (dir_taken_q == $past(btb_taken) && dir_src_q == 2'b10));

  // R12: valid follows one cycle later
  a_r12_dir_latency: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dir_valid_q == $past(dec_valid)));
endmodule

// File: rtl/hybrid_bpred.sv
module hybrid_bpred
  import bpred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  parameter int ALIGN  = 2,
  localparam int IW    = $clog2(DEPTH),
  localparam int TAG_W = ADDR_W - IW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic              lk_taken_o,
  output logic [ADDR_W-1:0] lk_target_o,
  input  logic              dec_valid_i,
  input  logic              dec_btb_hit_i,
  input  logic              dec_btb_taken_i,
  input  logic              dec_disp_neg_i,
  input  logic [1:0]        dec_hint_i,
  output logic              dir_valid_o,
  output logic              dir_taken_o,
  output logic [1:0]        dir_src_o,
  input  logic              rt_valid_i,
  input  logic [ADDR_W-1:0] rt_addr_i,
  input  logic              rt_taken_i,
  input  logic [ADDR_W-1:0] rt_target_i
);
  logic [IW-1:0]    lk_idx, rt_idx;
  logic [TAG_W-1:0] lk_tag, rt_tag;
  logic             lk_hit_q, lk_ctr_hi_q, tgt_we;

  assign lk_idx = lk_addr_i[ALIGN +: IW];
  assign rt_idx = rt_addr_i[ALIGN +: IW];
  assign lk_tag = {lk_addr_i[ADDR_W-1:ALIGN+IW], lk_addr_i[ALIGN-1:0]};
  assign rt_tag = {rt_addr_i[ADDR_W-1:ALIGN+IW], rt_addr_i[ALIGN-1:0]};

  bpred_btb_meta #(.DEPTH(DEPTH), .TAG_W(TAG_W)) meta_i (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid_i), .lk_idx(lk_idx), .lk_tag(lk_tag),
    .lk_hit_q(lk_hit_q), .lk_ctr_hi_q(lk_ctr_hi_q),
    .rt_valid(rt_valid_i), .rt_idx(rt_idx), .rt_tag(rt_tag),
    .rt_taken(rt_taken_i), .tgt_we(tgt_we)
  );

  bpred_tgt_ram #(.DEPTH(DEPTH), .DW(ADDR_W)) tgt_i (
    .clk(clk), .we(tgt_we), .waddr(rt_idx), .wdata(rt_target_i),
    .re(lk_valid_i), .raddr(lk_idx), .rdata(lk_target_o)
  );

  assign lk_hit_o   = lk_hit_q;
  assign lk_taken_o = lk_hit_q && lk_ctr_hi_q;

  bpred_dir_select sel_i (
    .clk(clk), .rst(rst),
    .dec_valid(dec_valid_i), .btb_hit(dec_btb_hit_i),
    .btb_taken(dec_btb_taken_i), .disp_neg(dec_disp_neg_i),
    .hint(dec_hint_i),
    .dir_valid_q(dir_valid_o), .dir_taken_q(dir_taken_o),
    .dir_src_q(dir_src_o)
  );

  // R2: a prediction of taken implies a hit
  a_r2_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
    lk_taken_o |-> lk_hit_o);

  // R2: no lookup request, no hit
  a_r2_hit_needs_req: assert property (@(posedge clk) disable iff (rst)
    !lk_valid_i |=> !lk_hit_o);
endmodule

// File: tb/hybrid_bpred_tb_top.sv
module hybrid_bpred_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid_i = 0, dec_valid_i = 0, dec_btb_hit_i = 0, dec_btb_taken_i = 0;
  logic        dec_disp_neg_i = 0, rt_valid_i = 0, rt_taken_i = 0;
  logic [1:0]  dec_hint_i = 0;
  logic [31:0] lk_addr_i = 0, rt_addr_i = 0, rt_target_i = 0;
  logic        lk_hit_o, lk_taken_o, dir_valid_o, dir_taken_o;
  logic [31:0] lk_target_o;
  logic [1:0]  dir_src_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [31:0] IDX_MASK = 32'h0000_003C;

  bit          mv   [16];
  logic [31:0] mtag [16];
  logic [31:0] mtgt [16];
  logic [1:0]  mctr [16];

  always #5 clk = ~clk;

  hybrid_bpred dut_i (.*);

  function automatic int idx_of(input logic [31:0] a);
    return int'(a[5:2]);
  endfunction

  function automatic logic [31:0] mk_addr(input int t, input int i);
    return (32'(t) << 6) | (32'(i) << 2);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req,
                     input bit lv, input logic [31:0] la,
                     input bit rv, input logic [31:0] ra, input bit rtk, input logic [31:0] rtg,
                     input bit dv, input bit dh, input bit dt, input bit dn, input logic [1:0] hn);
    int li, ri;
    bit ehit, etk, edt;
    logic [31:0] etgt;
    logic [1:0] esrc;
    @(negedge clk);
    lk_valid_i = lv; lk_addr_i = la;
    rt_valid_i = rv; rt_addr_i = ra; rt_taken_i = rtk; rt_target_i = rtg;
    dec_valid_i = dv; dec_btb_hit_i = dh; dec_btb_taken_i = dt;
    dec_disp_neg_i = dn; dec_hint_i = hn;
    li   = idx_of(la);
    ehit = mv[li] && (mtag[li] == (la & ~IDX_MASK));
    etk  = ehit && (mctr[li] >= 2'd2);
    etgt = mtgt[li];
    if (dh)              begin edt = dt;   esrc = 2'b10; end
    else if (hn == 2'b10) begin edt = 1'b1; esrc = 2'b01; end
    else if (hn == 2'b01) begin edt = 1'b0; esrc = 2'b01; end
    else                 begin edt = dn;   esrc = 2'b00; end
    @(posedge clk);
    #1;
    if (lv) begin
      check(req, "lk_hit", 32'(lk_hit_o), 32'(ehit));
      check(req, "lk_taken", 32'(lk_taken_o), 32'(etk));
      if (ehit) check(req, "lk_target", lk_target_o, etgt);
    end else begin
      check(req, "lk_hit idle", 32'(lk_hit_o), 32'd0);
    end
    check(req, "dir_valid", 32'(dir_valid_o), 32'(dv));
    if (dv) begin
      check(req, "dir_taken", 32'(dir_taken_o), 32'(edt));
      check(req, "dir_src", 32'(dir_src_o), 32'(esrc));
    end
    if (rv) begin
      ri = idx_of(ra);
      if (mv[ri] && mtag[ri] == (ra & ~IDX_MASK)) begin
        if (rtk) begin
          mctr[ri] = (mctr[ri] == 2'd3) ? 2'd3 : mctr[ri] + 2'd1;
          mtgt[ri] = rtg;
        end else begin
          mctr[ri] = (mctr[ri] == 2'd0) ? 2'd0 : mctr[ri] - 2'd1;
        end
      end else if (rtk) begin
        mv[ri] = 1'b1; mtag[ri] = ra & ~IDX_MASK; mtgt[ri] = rtg; mctr[ri] = 2'd2;
      end
    end
  endtask

  task automatic look(input string req, input logic [31:0] a);
    cyc(req, 1, a, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00);
  endtask

  task automatic retire(input string req, input logic [31:0] a, input bit tk, input logic [31:0] t);
    cyc(req, 0, 0, 1, a, tk, t, 0, 0, 0, 0, 2'b00);
  endtask

  task automatic decode(input string req, input bit dh, input bit dt, input bit dn, input logic [1:0] hn);
    cyc(req, 0, 0, 0, 0, 0, 0, 1, dh, dt, dn, hn);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    for (int i = 0; i < 16; i++) begin mv[i] = 0; mtag[i] = 0; mtgt[i] = 0; mctr[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    check("R1", "dir_valid after reset", 32'(dir_valid_o), 32'd0);
    for (int i = 0; i < 4; i++) look("R1", mk_addr(i, i * 3));

    // R3 R4 R5 R6 R12: priority cross
    for (int h = 0; h < 4; h++)
      for (int n = 0; n < 2; n++) begin
        decode((h == 1 || h == 2) ? "R5" : (n != 0 ? "R3" : "R4"), 0, 0, n[0], 2'(h));
        decode("R6", 1, 1, n[0], 2'(h));
        decode("R6", 1, 0, n[0], 2'(h));
      end
    cyc("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b10);

    // R7: allocation
    a = mk_addr(1, 5);
    retire("R7", a, 1, 32'h0000_4000);
    look("R7", a);

    // R8: not-taken miss at aliasing address keeps the resident entry
    b = mk_addr(2, 5);
    retire("R8", b, 0, 32'h0000_9990);
    look("R8", b);
    look("R8", a);

    // R9: training sequence 2 -> 1 -> 0 -> 0 -> 1 -> 2 -> 3 -> 3
    retire("R9", a, 0, 0); look("R9", a);
    retire("R9", a, 0, 0); look("R9", a);
    retire("R9", a, 0, 0); look("R9", a);
    retire("R9", a, 1, 32'h0000_4000); look("R9", a);
    retire("R9", a, 1, 32'h0000_4000); look("R9", a);
    retire("R9", a, 1, 32'h0000_4000); look("R9", a);
    retire("R9", a, 1, 32'h0000_4000); look("R9", a);
    retire("R9", a, 0, 0); look("R9", a);

    // R10: target update rules
    retire("R10", a, 0, 32'hDEAD_0000); look("R10", a);
    retire("R10", a, 1, 32'h0000_7770); look("R10", a);

    // R11: same-cycle lookup and retire on one index
    b = mk_addr(3, 9);
    cyc("R11", 1, b, 1, b, 1, 32'h0000_1230, 0, 0, 0, 0, 2'b00);
    look("R11", b);
    cyc("R11", 1, b, 1, b, 1, 32'h0000_5550, 0, 0, 0, 0, 2'b00);
    look("R11", b);

    // R2 R9: random traffic over a small address pool
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] la, ra;
      la = mk_addr(int'($urandom_range(3)), int'($urandom_range(15)));
      ra = mk_addr(int'($urandom_range(3)), int'($urandom_range(15)));
      cyc("R2", 1'($urandom_range(1)), la,
          1'($urandom_range(1)), ra, 1'($urandom_range(3) != 0), {$urandom() & 32'hFFFF_FFFC},
          1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
          1'($urandom_range(1)), 2'($urandom_range(3)));
    end

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 16; i++) mv[i] = 0;
    look("R1", a);
    look("R1", b);

    finish_run();
  end
endmodule